// File: doc/BRIEF.md
# ADC result register bank

This block sits between an analog-to-digital converter and a CPU. When the converter reports a finished conversion, the block places the 10-bit result in one of four result registers, marks that register as holding unread data, and raises a shared end-of-conversion flag. The CPU reads each register as two bytes through a small read port. A read strobe on either byte of a register clears that register's unread mark and the shared flag.

The destination register depends on the mode input. When the mode input is low, the destination is fixed by the channel number: the two low channel bits select the register, so channels four apart share a register. When the mode input is high, one channel is converted over and over, and each new result goes to the next register in a 0, 1, 2, 3 rotation that then wraps. The rotation returns to register 0 when the mode input changes or when a new sequence is signalled. The block also contains a timer for the fixed conversion time. The timer counts a set number of clocks after a start pulse and then gives a one-cycle done pulse.

Top module: `adc_result_bank`

## Requirements
- R1: After `conv_start` is sampled while the timer is idle, `timer_busy` is high from the next cycle on. `timer_done` goes high exactly CONV_CYCLES (84) clock edges after the edge that sampled the start, stays high for one cycle only, and `timer_busy` is low in that same cycle.
- R2: A `conv_start` that arrives while `timer_busy` is high is ignored. It does not move the done pulse, and it produces no second done pulse.
- R3: With `fixed_repeat` low, a result marked by `res_valid` is stored in register `res_chan % 4`.
- R4: With `fixed_repeat` high, successive results are stored in registers 0, 1, 2 and 3 in turn, and then the sequence wraps to 0.
- R5: The rotation restarts at register 0 when `fixed_repeat` changes value or when `seq_start` is pulsed. A store in the same cycle as the restart goes to register 0.
- R6: `rd_addr[2:1]` selects the register and `rd_addr[0]` selects the byte (1 for upper, 0 for lower). The upper byte holds result bits 9:2. The lower byte holds result bits 1:0 in bits 7:6, zeros in bits 5:1, and the storage flag in bit 0. `rd_data` shows the addressed byte combinationally, and only `rd_en` has any side effect.
- R7: A store sets the storage flag of the register it writes. A read with `rd_en` of either byte of a register clears that register's flag at the next edge. Flags of the other registers are left unchanged.
- R8: `eoc_flag` goes to 1 on every store and to 0 after any read with `rd_en`.
- R9: When a store and a read happen in the same cycle, the store wins. The written register's flag and `eoc_flag` both end up at 1.
- R10: After reset, all result bytes read as 0, all flags are 0, `eoc_flag` is 0, and the timer is idle with no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Start pulse for the conversion timer |
| seq_start | input | 1 | Pulse that marks a new conversion sequence and restarts the rotation |
| fixed_repeat | input | 1 | 1 = rotating storage for a repeated single channel, 0 = storage selected by channel |
| res_valid | input | 1 | Strobe: a conversion result is present this cycle |
| res_chan | input | CHAN_W (3) | Channel number of the result |
| res_data | input | RES_W (10) | Conversion result |
| rd_en | input | 1 | CPU read strobe |
| rd_addr | input | SLOT_W+1 (3) | Register index in bits 2:1, byte select in bit 0 |
| rd_data | output | BYTE_W (8) | Addressed result byte |
| eoc_flag | output | 1 | End-of-conversion flag |
| timer_busy | output | 1 | Conversion timer is running |
| timer_done | output | 1 | One-cycle pulse at the end of the timed conversion |

## Verification
On every cycle, the assertions check the timer's contract: the done pulse is one cycle wide, it comes exactly at the end of the timed window, and a start on an idle timer is accepted. They also check that the end-of-conversion flag is set by stores and cleared by reads, and that a register's flag is set when it is written by channel and cleared when it is read. Some behaviour needs whole sequences to show, and only the bench's scenarios can show it. This covers the rotation order and its wrap, the restart on a mode change or a sequence pulse, the byte layout of the stored data, the fact that other registers' flags are left alone, and the store-wins rule in a collision.

// File: rtl/adc_bank_pkg.sv
`timescale 1ns/1ps
package adc_bank_pkg;

   typedef enum logic {
      TMR_IDLE = 1'b0,
      TMR_RUN  = 1'b1
   } tmr_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/adc_conv_timer.sv
`timescale 1ns/1ps
module adc_conv_timer
   import adc_bank_pkg::*;
#(
   parameter int CONV_CYCLES = 84,
   localparam int CNT_W = $clog2(CONV_CYCLES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   tmr_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TMR_IDLE;
         cnt_q   <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            TMR_IDLE: begin
               if (start_i) begin
                  state_q <= TMR_RUN;
                  cnt_q   <= CNT_W'(CONV_CYCLES - 1);
               end
            end
            default: begin
               if (cnt_q == '0) begin
                  state_q <= TMR_IDLE;
                  done_o  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
         endcase
      end
   end

   assign busy_o = (state_q == TMR_RUN);

endmodule

// File: rtl/adc_slot_select.sv
`timescale 1ns/1ps
module adc_slot_select #(
   parameter int NUM_SLOTS = 4,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_i,
   input  logic              fixed_i,
   input  logic              seq_start_i,
   input  logic [SLOT_W-1:0] chan_lo_i,
   output logic [SLOT_W-1:0] slot_o
);

   logic              mode_q;
   logic [SLOT_W-1:0] ptr_q;
   logic              restart;
   logic [SLOT_W-1:0] base;

   assign restart = seq_start_i || (fixed_i != mode_q);
   assign base    = restart ? '0 : ptr_q;
   assign slot_o  = fixed_i ? base : chan_lo_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         ptr_q  <= '0;
      end else begin
         mode_q <= fixed_i;
         if (store_i && fixed_i) begin
            ptr_q <= base + SLOT_W'(1);
         end else if (restart) begin
            ptr_q <= '0;
         end
      end
   end

endmodule

// File: rtl/adc_result_store.sv
`timescale 1ns/1ps
module adc_result_store #(
   parameter int RES_W     = 10,
   parameter int NUM_SLOTS = 4,
   parameter int BYTE_W    = 8,
   localparam int SLOT_W = $clog2(NUM_SLOTS),
   localparam int ADDR_W = SLOT_W + 1,
   localparam int LOW_W  = RES_W - BYTE_W,
   localparam int PAD_W  = BYTE_W - 1 - LOW_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 store_i,
   input  logic [SLOT_W-1:0]    slot_i,
   input  logic [RES_W-1:0]     data_i,
   input  logic                 rd_en_i,
   input  logic [ADDR_W-1:0]    rd_addr_i,
   output logic [BYTE_W-1:0]    rd_data_o,
   output logic [NUM_SLOTS-1:0] flags_o
);

   logic [RES_W-1:0]  res_arr [NUM_SLOTS];
   logic [SLOT_W-1:0] rd_slot;

   assign rd_slot = rd_addr_i[ADDR_W-1:1];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic             wr_hit;
      logic             rd_hit;
      logic [RES_W-1:0] data_q;
      logic             flg_q;

      assign wr_hit = store_i && (slot_i == SLOT_W'(g));
      assign rd_hit = rd_en_i && (rd_slot == SLOT_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q <= '0;
            flg_q  <= 1'b0;
         end else if (wr_hit) begin
            data_q <= data_i;
            flg_q  <= 1'b1;
         end else if (rd_hit) begin
            flg_q  <= 1'b0;
         end
      end

      assign res_arr[g]  = data_q;
      assign flags_o[g]  = flg_q;
   end

   logic [RES_W-1:0]  sel_res;
   logic [BYTE_W-1:0] upper_b;
   logic [BYTE_W-1:0] lower_b;

   assign sel_res = res_arr[rd_slot];
   assign upper_b = sel_res[RES_W-1 -: BYTE_W];

   if (PAD_W > 0) begin : g_lower_pad
      assign lower_b = {sel_res[LOW_W-1:0], {PAD_W{1'b0}}, flags_o[rd_slot]};
   end else begin : g_lower_full
      assign lower_b = {sel_res[LOW_W-1:0], flags_o[rd_slot]};
   end

   assign rd_data_o = rd_addr_i[0] ? upper_b : lower_b;

endmodule

// File: rtl/adc_result_bank.sv
`timescale 1ns/1ps
module adc_result_bank
   import adc_bank_pkg::*;
#(
   parameter int RES_W       = 10,
   parameter int CHAN_W      = 3,
   parameter int NUM_SLOTS   = 4,
   parameter int BYTE_W      = 8,
   parameter int CONV_CYCLES = 84,
   localparam int SLOT_W = $clog2(NUM_SLOTS),
   localparam int ADDR_W = SLOT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_start,
   input  logic              seq_start,
   input  logic              fixed_repeat,
   input  logic              res_valid,
   input  logic [CHAN_W-1:0] res_chan,
   input  logic [RES_W-1:0]  res_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic              eoc_flag,
   output logic              timer_busy,
   output logic              timer_done
);

   if (!is_pow2(NUM_SLOTS) || NUM_SLOTS < 2) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two, at least 2");
   end
   if (CHAN_W <= SLOT_W) begin : g_bad_chan
      $error("CHAN_W must exceed the slot index width");
   end
   if (RES_W <= BYTE_W || RES_W > 2 * BYTE_W - 1) begin : g_bad_res
      $error("RES_W must fit an upper byte plus a lower byte with a flag bit");
   end
   if (CONV_CYCLES < 2) begin : g_bad_conv
      $error("CONV_CYCLES must be at least 2");
   end

   logic [SLOT_W-1:0]    wr_slot;
   logic [NUM_SLOTS-1:0] slot_flags;
   logic                 unused_chan_hi;

   assign unused_chan_hi = ^res_chan[CHAN_W-1:SLOT_W];

   adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (conv_start),
      .busy_o  (timer_busy),
      .done_o  (timer_done)
   );

   adc_slot_select #(.NUM_SLOTS(NUM_SLOTS)) sel_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .store_i     (res_valid),
      .fixed_i     (fixed_repeat),
      .seq_start_i (seq_start),
      .chan_lo_i   (res_chan[SLOT_W-1:0]),
      .slot_o      (wr_slot)
   );

   adc_result_store #(
      .RES_W     (RES_W),
      .NUM_SLOTS (NUM_SLOTS),
      .BYTE_W    (BYTE_W)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .store_i   (res_valid),
      .slot_i    (wr_slot),
      .data_i    (res_data),
      .rd_en_i   (rd_en),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .flags_o   (slot_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_flag <= 1'b0;
      end else if (res_valid) begin
         eoc_flag <= 1'b1;
      end else if (rd_en) begin
         eoc_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_result_bank_chk.sv
`timescale 1ns/1ps
module adc_result_bank_chk #(
   parameter int NUM_SLOTS   = 4,
   parameter int CONV_CYCLES = 84,
   localparam int SLOT_W = $clog2(NUM_SLOTS),
   localparam int RC_W   = $clog2(CONV_CYCLES + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 conv_start,
   input logic                 timer_busy,
   input logic                 timer_done,
   input logic                 res_valid,
   input logic                 fixed_repeat,
   input logic [SLOT_W-1:0]    res_slot,
   input logic                 rd_en,
   input logic [SLOT_W-1:0]    rd_slot,
   input logic                 eoc_flag,
   input logic [NUM_SLOTS-1:0] slot_flags
);

   logic [RC_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (timer_busy) begin
         run_cnt <= run_cnt + RC_W'(1);
      end else begin
         run_cnt <= '0;
      end
   end

   // R1
   timer_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start && !timer_busy |=> timer_busy);

   // R1
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timer_done |=> !timer_done);

   // R1
   done_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timer_done |-> (run_cnt == RC_W'(CONV_CYCLES)) && !timer_busy);

   // R2
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timer_busy |-> run_cnt < RC_W'(CONV_CYCLES));

   // R8
   eoc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> eoc_flag);

   // R8
   eoc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !res_valid |=> !eoc_flag);

   // R3
   chan_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !fixed_repeat |=> slot_flags[$past(res_slot)]);

   // R7
   read_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !res_valid |=> !slot_flags[$past(rd_slot)]);

endmodule

bind adc_result_bank adc_result_bank_chk #(
   .NUM_SLOTS   (NUM_SLOTS),
   .CONV_CYCLES (CONV_CYCLES)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .conv_start   (conv_start),
   .timer_busy   (timer_busy),
   .timer_done   (timer_done),
   .res_valid    (res_valid),
   .fixed_repeat (fixed_repeat),
   .res_slot     (res_chan[SLOT_W-1:0]),
   .rd_en        (rd_en),
   .rd_slot      (rd_addr[ADDR_W-1:1]),
   .eoc_flag     (eoc_flag),
   .slot_flags   (slot_flags)
);

// File: tb/adc_result_bank_tb_top.sv
`timescale 1ns/1ps
module adc_result_bank_tb_top;

   typedef struct packed {
      logic       fixed;
      logic [2:0] chan;
      logic [9:0] data;
      logic [1:0] slot;
   } vec_t;

   localparam int NVEC = 13;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 3'd0, 10'h3A5, 2'd0},
      '{1'b0, 3'd1, 10'h155, 2'd1},
      '{1'b0, 3'd2, 10'h2AA, 2'd2},
      '{1'b0, 3'd3, 10'h0FF, 2'd3},
      '{1'b0, 3'd4, 10'h300, 2'd0},
      '{1'b0, 3'd5, 10'h001, 2'd1},
      '{1'b0, 3'd6, 10'h3FE, 2'd2},
      '{1'b0, 3'd7, 10'h27C, 2'd3},
      '{1'b1, 3'd5, 10'h111, 2'd0},
      '{1'b1, 3'd5, 10'h222, 2'd1},
      '{1'b1, 3'd5, 10'h333, 2'd2},
      '{1'b1, 3'd5, 10'h044, 2'd3},
      '{1'b1, 3'd5, 10'h1C3, 2'd0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_start = 1'b0;
   logic       seq_start = 1'b0;
   logic       fixed_repeat = 1'b0;
   logic       res_valid = 1'b0;
   logic [2:0] res_chan = '0;
   logic [9:0] res_data = '0;
   logic       rd_en = 1'b0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       eoc_flag;
   logic       timer_busy;
   logic       timer_done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   adc_result_bank dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .conv_start   (conv_start),
      .seq_start    (seq_start),
      .fixed_repeat (fixed_repeat),
      .res_valid    (res_valid),
      .res_chan     (res_chan),
      .res_data     (res_data),
      .rd_en        (rd_en),
      .rd_addr      (rd_addr),
      .rd_data      (rd_data),
      .eoc_flag     (eoc_flag),
      .timer_busy   (timer_busy),
      .timer_done   (timer_done)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_store(input logic fx, input logic [2:0] ch, input logic [9:0] d);
      fixed_repeat = fx;
      res_chan     = ch;
      res_data     = d;
      res_valid    = 1'b1;
      @(posedge clk); #1;
      res_valid    = 1'b0;
   endtask

   task automatic do_read(input logic [2:0] a);
      rd_addr = a;
      rd_en   = 1'b1;
      @(posedge clk); #1;
      rd_en   = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] v);
      rd_addr = a;
      #0.5;
      v = rd_data;
   endtask

   task automatic check_slot(input string req, input logic [1:0] s, input logic [9:0] d,
                             input logic flg);
      logic [7:0] v;
      peek({s, 1'b1}, v);
      check(req, {8'h0, v}, {8'h0, d[9:2]});
      peek({s, 1'b0}, v);
      check(req, {8'h0, v}, {8'h0, d[1:0], 5'b0, flg});
   endtask

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      int extra;

      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R10: reset state
      check("R10 eoc", {15'h0, eoc_flag}, 16'h0);
      check("R10 busy", {15'h0, timer_busy}, 16'h0);
      check("R10 done", {15'h0, timer_done}, 16'h0);
      for (int a = 0; a < 8; a++) begin
         peek(3'(a), v);
         check("R10 bytes", {8'h0, v}, 16'h0);
      end

      // R3 R4 R6: vector table walk
      for (int i = 0; i < NVEC; i++) begin
         do_store(VECS[i].fixed, VECS[i].chan, VECS[i].data);
         check_slot(VECS[i].fixed ? "R4 rotate" : "R3 chan map R6",
                    VECS[i].slot, VECS[i].data, 1'b1);
      end

      // R8: set by stores
      check("R8 eoc set", {15'h0, eoc_flag}, 16'h1);

      // R7: read upper of slot 1 clears only that flag
      do_read(3'b011);
      peek(3'b010, v);
      check("R7 flag1 cleared", {15'h0, v[0]}, 16'h0);
      peek(3'b100, v);
      check("R7 flag2 kept", {15'h0, v[0]}, 16'h1);
      check("R8 eoc cleared", {15'h0, eoc_flag}, 16'h0);
      // R7: read lower byte of slot 2 clears it too
      do_read(3'b100);
      peek(3'b100, v);
      check("R7 lower read clears", {15'h0, v[0]}, 16'h0);
      peek(3'b000, v);
      check("R7 flag0 kept", {15'h0, v[0]}, 16'h1);

      // R9: store and read of slot 3 in the same cycle
      fixed_repeat = 1'b0;
      res_chan  = 3'd3;
      res_data  = 10'h2B7;
      res_valid = 1'b1;
      rd_addr   = 3'b110;
      rd_en     = 1'b1;
      @(posedge clk); #1;
      res_valid = 1'b0;
      rd_en     = 1'b0;
      check_slot("R9 store wins", 2'd3, 10'h2B7, 1'b1);
      check("R9 eoc kept", {15'h0, eoc_flag}, 16'h1);

      // R5: restart by sequence pulse and by mode change
      do_store(1'b1, 3'd5, 10'h0A1);
      do_store(1'b1, 3'd5, 10'h0B2);
      seq_start = 1'b1;
      @(posedge clk); #1;
      seq_start = 1'b0;
      do_store(1'b1, 3'd5, 10'h0C3);
      check_slot("R5 seq restart", 2'd0, 10'h0C3, 1'b1);
      check_slot("R5 slot1 untouched", 2'd1, 10'h0B2, 1'b1);
      do_store(1'b1, 3'd5, 10'h0D4);
      fixed_repeat = 1'b0;
      @(posedge clk); #1;
      do_store(1'b1, 3'd5, 10'h0E5);
      check_slot("R5 mode restart", 2'd0, 10'h0E5, 1'b1);
      check_slot("R5 slot1 kept", 2'd1, 10'h0D4, 1'b1);

      // R1 R2: timer with an ignored second start
      conv_start = 1'b1;
      @(posedge clk); #1;
      conv_start = 1'b0;
      check("R1 busy after start", {15'h0, timer_busy}, 16'h1);
      n = 0;
      while (!timer_done && n < 200) begin
         conv_start = (n == 10);
         @(posedge clk); #1;
         n++;
      end
      conv_start = 1'b0;
      check("R1 R2 done delay", 16'(n), 16'd84);
      check("R1 busy low at done", {15'h0, timer_busy}, 16'h0);
      @(posedge clk); #1;
      check("R1 done one cycle", {15'h0, timer_done}, 16'h0);
      extra = 0;
      for (int k = 0; k < 100; k++) begin
         if (timer_done) extra++;
         @(posedge clk); #1;
      end
      check("R2 no second done", 16'(extra), 16'd0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule